// File: doc/BRIEF.md
# Event Timer Global Register File

This block is the shared register front end of a multi-channel, high-precision event timer. It sits on a simple single-cycle read/write bus that addresses a 1024-byte window. It owns the registers that are common to all channels:

- a read-only capability word that reports the revision, the channel count, the counter width, legacy-route support, a vendor code and the tick period;
- a two-bit configuration register holding the overall enable and the legacy-route select;
- a per-channel interrupt status register;
- a 64-bit main counter.

The main counter advances on a tick enable input, and only while the overall enable is set.

Accesses that land in a channel's 32-byte window are not handled here. The block turns them into a registered strobe that carries the channel index, the register within the window, the half selection and the write data. The selected channel then returns its read data on a shared input. The comparators inside each channel are outside this block. The channels receive the running count and the status-clear pulses from it.

Accesses may be 4 or 8 bytes wide. Address bit 2 picks the upper 32-bit half of a 64-bit register.

Top module: `evt_timer_regs`

## Requirements
- R1: The capability word reads as {tick period in fs (32 bits, default 10,000,000), vendor code (16 bits), bit 15 = 1 legacy-route capable, bit 14 = 0, bit 13 = 1 (64-bit counter), bits 12:8 = channel count minus one, bits 7:0 = revision 1}. Writes to it change nothing.
- R2: Global offsets are as follows: capability 0x00, configuration 0x10, status 0x20, main counter 0xF0. When address bit 2 is 1, the upper half of the register is reached and is returned in rd_data[31:0]. A 4-byte read at bit 2 = 0 returns the lower half. In both cases rd_data[63:32] is zero. An 8-byte read at bit 2 = 0 returns all 64 bits. Writes take bus_wdata[31:0] for a half, or all 64 bits for an 8-byte write at bit 2 = 0.
- R3: In the configuration register, only bit 0 (overall enable, driving cfg_enable) and bit 1 (legacy route, driving cfg_legacy) can be written. They are written by a lower-half write. All other bits read as zero.
- R4: The main counter increases by exactly one on each clock edge at which tick_en is high and the overall enable is set. Otherwise it holds its value. count_value shows it.
- R5: The main counter can be written by halves or whole at any time. At a given edge a write takes priority over an increment. The counter wraps from all ones to zero, and carries from the lower half into the upper half.
- R6: A status bit is set by a one-cycle pulse on its ch_irq_set line. Writing 1 to a set status bit clears it and gives a one-cycle pulse on the matching sts_clear bit. Writing 1 to a clear bit, or writing 0, does nothing and gives no pulse. If a set and a clear meet at the same edge, the set wins.
- R7: Channel n owns the window 0x100 + 0x20*n. Offset +0x00 is configuration (ch_reg = 0), +0x08 is comparator (ch_reg = 1) and +0x10 is message route (ch_reg = 2). An access there gives, one cycle later, ch_stb together with ch_idx, ch_reg, ch_wr, ch_upper (address bit 2), ch_wide and ch_wdata. A read returns ch_rdata, with the half selection of R2 applied.
- R8: The following read as zero, and writes to them have no effect and give no ch_stb: unmapped global offsets, offset +0x18 in a channel window, and any channel index at or above the channel count.
- R9: After reset, the configuration, status and counter are zero, and every strobe and valid output is low.
- R10: A read request gives rd_valid for one cycle, on the following cycle. rd_data then holds the register value as it was at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| tick_en | input | 1 | Counter tick enable |
| ch_irq_set | input | NUM_CH | Per-channel status set pulses |
| ch_rdata | input | 64 | Read data from the channel named by ch_idx/ch_reg |
| cfg_enable | output | 1 | Overall enable |
| cfg_legacy | output | 1 | Legacy route select |
| count_value | output | 64 | Main counter value |
| sts_clear | output | NUM_CH | Per-channel status clear pulses |
| ch_stb | output | 1 | Channel register access strobe |
| ch_wr | output | 1 | Channel access is a write |
| ch_idx | output | 5 | Channel index |
| ch_reg | output | 2 | Register within the channel window |
| ch_upper | output | 1 | Upper half selected |
| ch_wide | output | 1 | 8-byte channel access |
| ch_wdata | output | 64 | Channel write data |

## Verification
A wrong enable or counter state shows on count_value at the first clock edge after the fault. The bench therefore counts exact tick windows and checks wrap and carry values. A status bit that is lost or stuck shows one cycle later: a missing or extra sts_clear pulse appears on the write that should clear the bit, and the next status read returns the wrong bit. A decode error shows up as a nonzero read of an unmapped or out-of-range window, or as a channel strobe with the wrong index or register, one cycle after the access.

// File: rtl/evt_pkg.sv
package evt_pkg;

  localparam int MAX_CH   = 32;
  localparam int CH_IDX_W = 5;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CAP,
    TGT_CFG,
    TGT_STS,
    TGT_CNT,
    TGT_CH
  } tgt_e;

  typedef struct packed {
    tgt_e                tgt;
    logic [CH_IDX_W-1:0] ch;
    logic [1:0]          creg;
  } dec_t;

  // Put a half or a whole word of new data into an old 64-bit value.
  function automatic logic [63:0] half_merge(input logic [63:0] old_v,
                                             input logic [63:0] wd,
                                             input logic        upper,
                                             input logic        wide);
    if (upper)     return {wd[31:0], old_v[31:0]};
    else if (wide) return wd;
    else           return {old_v[63:32], wd[31:0]};
  endfunction

  // Select the returned part of a 64-bit register value.
  function automatic logic [63:0] half_pick(input logic [63:0] v,
                                            input logic        upper,
                                            input logic        wide);
    if (upper)     return {32'h0, v[63:32]};
    else if (wide) return v;
    else           return {32'h0, v[31:0]};
  endfunction

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam int WIN_W = ADDR_W - 5;

  logic [ADDR_W-1:0] win;
  logic [WIN_W-1:0]  win_idx;
  logic              unused_low;

  assign win        = addr - {{(ADDR_W-9){1'b0}}, 9'h100};
  assign win_idx    = win[ADDR_W-1:5];
  assign unused_low = ^addr[1:0];

  always_comb begin
    dec.tgt  = TGT_NONE;
    dec.ch   = '0;
    dec.creg = '0;
    if (addr[ADDR_W-1:8] == '0) begin
      unique case (addr[7:3])
        5'h00:   dec.tgt = TGT_CAP;
        5'h02:   dec.tgt = TGT_CFG;
        5'h04:   dec.tgt = TGT_STS;
        5'h1E:   dec.tgt = TGT_CNT;
        default: dec.tgt = TGT_NONE;
      endcase
    end else if ((int'(win_idx) < NUM_CH) && (addr[4:3] != 2'b11)) begin
      dec.tgt  = TGT_CH;
      dec.ch   = CH_IDX_W'(win_idx);
      dec.creg = addr[4:3];
    end
  end

endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        wr_upper,
  input  logic        wr_wide,
  input  logic [63:0] wr_data,
  output logic [63:0] count
);

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (wr_en)       count <= half_merge(count, wr_data, wr_upper, wr_wide);
    else if (run && tick) count <= count + 64'd1;
  end

  // R4: no write and no enabled tick means the count holds.
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !(run && tick)) |=> $stable(count));

  // R4/R5: an enabled tick with no write steps by one, wrapping at the top.
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !wr_en) |=> (count - $past(count)) == 64'd1);

endmodule

// File: rtl/evt_int_status.sv
module evt_int_status #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_in,
  input  logic              clr_wr,
  input  logic [NUM_CH-1:0] clr_data,
  output logic [NUM_CH-1:0] sts,
  output logic [NUM_CH-1:0] clr_stb
);

  logic [NUM_CH-1:0] clr_mask;

  assign clr_mask = clr_wr ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts     <= '0;
      clr_stb <= '0;
    end else begin
      sts     <= (sts & ~clr_mask) | set_in;
      clr_stb <= clr_mask & sts;
    end
  end

  // R6: a clear pulse only for a bit that was set before the write.
  p_clr_only_set_r6: assert property (@(posedge clk) disable iff (rst)
    (|clr_stb) |-> ((clr_stb & ~$past(sts)) == '0));

  // R6: a set pulse always lands, even against a clear.
  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (|set_in) |=> ((sts & $past(set_in)) == $past(set_in)));

endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
  localparam int         ADDR_W    = (NUM_CH > 24) ? 11 : 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_wide,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [63:0]         bus_wdata,
  output logic                rd_valid,
  output logic [63:0]         rd_data,
  input  logic                tick_en,
  input  logic [NUM_CH-1:0]   ch_irq_set,
  input  logic [63:0]         ch_rdata,
  output logic                cfg_enable,
  output logic                cfg_legacy,
  output logic [63:0]         count_value,
  output logic [NUM_CH-1:0]   sts_clear,
  output logic                ch_stb,
  output logic                ch_wr,
  output logic [CH_IDX_W-1:0] ch_idx,
  output logic [1:0]          ch_reg,
  output logic                ch_upper,
  output logic                ch_wide,
  output logic [63:0]         ch_wdata
);

  localparam logic [63:0] CAP_VAL = {PERIOD_FS, VENDOR_ID, 1'b1, 1'b0, 1'b1,
                                     5'(NUM_CH - 1), 8'h01};

  if (NUM_CH < 3 || NUM_CH > MAX_CH) begin : g_bad_count
    $error("evt_timer_regs: NUM_CH must lie in 3..32");
  end

  dec_t              dec;
  logic              upper;
  logic              acc_wr, acc_rd;
  logic [1:0]        cfg_q;
  logic [NUM_CH-1:0] sts;
  logic [NUM_CH-1:0] sts_wdata;
  logic [63:0]       glob_val;
  logic [63:0]       rd_glob_q;
  logic              rd_ch_q, rd_upper_q, rd_wide_q;

  assign upper  = bus_addr[2];
  assign acc_wr = bus_sel && bus_wr;
  assign acc_rd = bus_sel && !bus_wr;

  evt_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  evt_main_counter i_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (cfg_q[0]),
    .tick     (tick_en),
    .wr_en    (acc_wr && dec.tgt == TGT_CNT),
    .wr_upper (upper),
    .wr_wide  (bus_wide),
    .wr_data  (bus_wdata),
    .count    (count_value)
  );

  assign sts_wdata = upper ? '0 : bus_wdata[NUM_CH-1:0];

  evt_int_status #(.NUM_CH(NUM_CH)) i_sts (
    .clk      (clk),
    .rst      (rst),
    .set_in   (ch_irq_set),
    .clr_wr   (acc_wr && dec.tgt == TGT_STS),
    .clr_data (sts_wdata),
    .sts      (sts),
    .clr_stb  (sts_clear)
  );

  // Configuration: two writable bits in the lower half.
  always_ff @(posedge clk) begin
    if (rst)                                      cfg_q <= '0;
    else if (acc_wr && dec.tgt == TGT_CFG && !upper) cfg_q <= bus_wdata[1:0];
  end

  assign cfg_enable = cfg_q[0];
  assign cfg_legacy = cfg_q[1];

  always_comb begin
    unique case (dec.tgt)
      TGT_CAP: glob_val = CAP_VAL;
      TGT_CFG: glob_val = {62'h0, cfg_q};
      TGT_STS: glob_val = 64'(sts);
      TGT_CNT: glob_val = count_value;
      default: glob_val = '0;
    endcase
  end

  // Read return path.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_glob_q  <= '0;
      rd_ch_q    <= 1'b0;
      rd_upper_q <= 1'b0;
      rd_wide_q  <= 1'b0;
    end else begin
      rd_valid   <= acc_rd;
      rd_glob_q  <= acc_rd ? half_pick(glob_val, upper, bus_wide) : '0;
      rd_ch_q    <= acc_rd && dec.tgt == TGT_CH;
      rd_upper_q <= upper;
      rd_wide_q  <= bus_wide;
    end
  end

  assign rd_data = rd_ch_q ? half_pick(ch_rdata, rd_upper_q, rd_wide_q) : rd_glob_q;

  // Channel access forwarding.
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_stb   <= 1'b0;
      ch_wr    <= 1'b0;
      ch_idx   <= '0;
      ch_reg   <= '0;
      ch_upper <= 1'b0;
      ch_wide  <= 1'b0;
      ch_wdata <= '0;
    end else begin
      ch_stb <= bus_sel && dec.tgt == TGT_CH;
      if (bus_sel && dec.tgt == TGT_CH) begin
        ch_wr    <= bus_wr;
        ch_idx   <= dec.ch;
        ch_reg   <= dec.creg;
        ch_upper <= upper;
        ch_wide  <= bus_wide;
        ch_wdata <= bus_wdata;
      end
    end
  end

  // R10: data valid only after a read request.
  p_rd_after_req_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_sel && !bus_wr));

  // R8: a channel strobe never names a channel beyond the count.
  p_ch_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    ch_stb |-> (int'(ch_idx) < NUM_CH) && (ch_reg != 2'b11));

  // R3: reserved configuration bits never appear on a global read.
  p_cfg_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && dec.tgt == TGT_CFG) |=> (rd_data[63:2] == '0));

endmodule

// File: tb/test_evt_timer_regs.sv
module test_evt_timer_regs;

  localparam int NUM_CH = 3;
  localparam logic [63:0] CAP = 64'h0098_9680_A5C3_A201;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        tick_en = 1'b0;
  logic [NUM_CH-1:0] ch_irq_set = '0;
  logic [63:0] ch_rdata;
  logic        cfg_enable, cfg_legacy;
  logic [63:0] count_value;
  logic [NUM_CH-1:0] sts_clear;
  logic        ch_stb, ch_wr, ch_upper, ch_wide;
  logic [4:0]  ch_idx;
  logic [1:0]  ch_reg;
  logic [63:0] ch_wdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Captured one cycle after each write.
  logic        w_stb, w_wr, w_upper, w_wide;
  logic [4:0]  w_idx;
  logic [1:0]  w_reg;
  logic [63:0] w_wdata;
  logic [NUM_CH-1:0] w_clr;
  logic [63:0] rv;

  always #5 clk = ~clk;

  // Channel model: read data tagged with the selected index and register.
  assign ch_rdata = {32'hC0DE_0000 | 32'(ch_idx), 32'h0000_B000 | 32'(ch_reg)};

  evt_timer_regs #(.NUM_CH(NUM_CH)) i_evt_timer_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .tick_en(tick_en), .ch_irq_set(ch_irq_set), .ch_rdata(ch_rdata),
    .cfg_enable(cfg_enable), .cfg_legacy(cfg_legacy), .count_value(count_value),
    .sts_clear(sts_clear), .ch_stb(ch_stb), .ch_wr(ch_wr), .ch_idx(ch_idx),
    .ch_reg(ch_reg), .ch_upper(ch_upper), .ch_wide(ch_wide), .ch_wdata(ch_wdata)
  );

  typedef struct packed {
    logic [9:0]  addr;
    logic        wide;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{10'h000, 1'b1, CAP,                    4'd1},  // R1 whole word
    '{10'h000, 1'b0, 64'h0000_0000_A5C3_A201, 4'd2},  // R2 lower half
    '{10'h004, 1'b0, 64'h0000_0000_0098_9680, 4'd2},  // R2 upper half
    '{10'h010, 1'b1, 64'h0,                   4'd9},  // R9 config
    '{10'h020, 1'b1, 64'h0,                   4'd9},  // R9 status
    '{10'h0F0, 1'b1, 64'h0,                   4'd9},  // R9 counter
    '{10'h008, 1'b1, 64'h0,                   4'd8},  // R8 unmapped
    '{10'h0E8, 1'b1, 64'h0,                   4'd8},  // R8 unmapped
    '{10'h140, 1'b1, 64'hC0DE_0002_0000_B000, 4'd7},  // R7 ch2 config
    '{10'h14C, 1'b0, 64'h0000_0000_C0DE_0002, 4'd7},  // R7 ch2 comparator upper
    '{10'h150, 1'b0, 64'h0000_0000_0000_B002, 4'd7},  // R7 ch2 route
    '{10'h158, 1'b1, 64'h0,                   4'd8},  // R8 slot +0x18
    '{10'h160, 1'b1, 64'h0,                   4'd8},  // R8 ch3 absent
    '{10'h3E0, 1'b1, 64'h0,                   4'd8}   // R8 high window
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic wd, input logic [63:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wide = wd; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    w_stb = ch_stb; w_wr = ch_wr; w_idx = ch_idx; w_reg = ch_reg;
    w_upper = ch_upper; w_wide = ch_wide; w_wdata = ch_wdata; w_clr = sts_clear;
  endtask

  task automatic bus_read(input logic [9:0] a, input logic wd, output logic [63:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wide = wd;
    @(negedge clk);
    bus_sel = 1'b0;
    n_chk++;
    if (rd_valid !== 1'b1) begin
      n_err++;
      $display("FAIL R10 rd_valid got=%b exp=1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state at the ports
    check("R9 cfg_enable", 64'(cfg_enable), 64'h0);
    check("R9 cfg_legacy", 64'(cfg_legacy), 64'h0);
    check("R9 count", count_value, 64'h0);
    check("R9 strobes", {61'h0, rd_valid, ch_stb, |sts_clear}, 64'h0);

    // Vector table walk (R1, R2, R7, R8, R9, R10)
    for (int i = 0; i < NV; i++) begin
      bus_read(VEC[i].addr, VEC[i].wide, rv);
      check($sformatf("R%0d table entry %0d addr %h", VEC[i].req, i, VEC[i].addr),
            rv, VEC[i].exp);
    end

    // R1: the capability word ignores writes
    bus_write(10'h000, 1'b1, '1);
    bus_read(10'h000, 1'b1, rv);
    check("R1 capability after write", rv, CAP);

    // R3: only two configuration bits stick
    bus_write(10'h010, 1'b1, '1);
    check("R3 cfg outputs", {62'h0, cfg_legacy, cfg_enable}, 64'h3);
    bus_read(10'h010, 1'b1, rv);
    check("R3 cfg read", rv, 64'h3);
    bus_write(10'h010, 1'b1, 64'h0);
    bus_write(10'h014, 1'b0, 64'hFFFF_FFFF);
    bus_read(10'h010, 1'b1, rv);
    check("R3 upper half write ignored", rv, 64'h0);

    // R5 / R2: halves of the counter
    bus_write(10'h0F0, 1'b0, 64'h89AB_CDEF);
    bus_write(10'h0F4, 1'b0, 64'h0123_4567);
    bus_read(10'h0F0, 1'b1, rv);
    check("R5 counter by halves", rv, 64'h0123_4567_89AB_CDEF);
    bus_read(10'h0F4, 1'b0, rv);
    check("R2 counter upper half", rv, 64'h0123_4567);

    // R4: disabled counter holds
    ticks(5);
    check("R4 hold while disabled", count_value, 64'h0123_4567_89AB_CDEF);

    // R4: exactly ten ticks while enabled
    bus_write(10'h010, 1'b0, 64'h1);
    ticks(10);
    bus_read(10'h0F0, 1'b1, rv);
    check("R4 ten ticks", rv, 64'h0123_4567_89AB_CDF9);
    check("R4 count port", count_value, 64'h0123_4567_89AB_CDF9);

    // R5: wrap from all ones
    bus_write(10'h010, 1'b0, 64'h0);
    bus_write(10'h0F0, 1'b1, '1);
    bus_write(10'h010, 1'b0, 64'h1);
    ticks(1);
    check("R5 wrap to zero", count_value, 64'h0);

    // R5: carry across the halves
    bus_write(10'h010, 1'b0, 64'h0);
    bus_write(10'h0F0, 1'b1, 64'hFFFF_FFFF);
    bus_write(10'h010, 1'b0, 64'h1);
    ticks(1);
    bus_read(10'h0F0, 1'b1, rv);
    check("R5 carry", rv, 64'h1_0000_0000);

    // R5: a write beats a tick at the same edge
    @(negedge clk);
    tick_en = 1'b1;
    bus_write(10'h0F0, 1'b1, 64'h100);
    check("R5 write over tick", count_value, 64'h100);
    tick_en = 1'b0;
    bus_write(10'h010, 1'b0, 64'h0);

    // R6: status set and write-one-to-clear
    @(negedge clk); ch_irq_set = 3'b010;
    @(negedge clk); ch_irq_set = 3'b000;
    bus_read(10'h020, 1'b1, rv);
    check("R6 status set", rv, 64'h2);
    bus_write(10'h020, 1'b0, 64'h1);
    check("R6 no pulse for clear bit", 64'(w_clr), 64'h0);
    bus_write(10'h020, 1'b0, 64'h0);
    check("R6 zero write no pulse", 64'(w_clr), 64'h0);
    bus_read(10'h020, 1'b1, rv);
    check("R6 status kept", rv, 64'h2);
    bus_write(10'h020, 1'b0, 64'h2);
    check("R6 clear pulse", 64'(w_clr), 64'h2);
    bus_read(10'h020, 1'b1, rv);
    check("R6 status cleared", rv, 64'h0);
    // set and clear of the same bit at one edge: set wins
    @(negedge clk); ch_irq_set = 3'b001;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'h020; bus_wide = 1'b0; bus_wdata = 64'h1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ch_irq_set = 3'b000;
    check("R6 clear pulse on collision", 64'(sts_clear), 64'h1);
    bus_read(10'h020, 1'b1, rv);
    check("R6 set wins", rv, 64'h1);

    // R7: channel strobes
    bus_write(10'h148, 1'b1, 64'hDEAD_BEEF_0000_1234);
    check("R7 strobe fields", {57'h0, w_stb, w_wr, w_idx},
          {57'h0, 1'b1, 1'b1, 5'd2});
    check("R7 reg/half/width", {60'h0, w_reg, w_upper, w_wide}, {60'h0, 2'd1, 1'b0, 1'b1});
    check("R7 write data", w_wdata, 64'hDEAD_BEEF_0000_1234);
    bus_write(10'h12C, 1'b0, 64'h55);
    check("R7 ch1 upper comparator", {57'h0, w_idx, w_reg, w_upper},
          {57'h0, 5'd1, 2'd1, 1'b1});

    // R8: out-of-range and unmapped writes
    bus_write(10'h160, 1'b1, 64'h77);
    check("R8 no strobe for ch3", 64'(w_stb), 64'h0);
    bus_write(10'h158, 1'b1, 64'h77);
    check("R8 no strobe for slot 3", 64'(w_stb), 64'h0);
    bus_write(10'h0E8, 1'b1, '1);
    bus_read(10'h0E8, 1'b1, rv);
    check("R8 unmapped stays zero", rv, 64'h0);
    bus_read(10'h010, 1'b1, rv);
    check("R8 cfg untouched", rv, 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule